// File: doc/BRIEF.md
# Banked Three-Port Shared Memory

This block is a synchronous shared memory with three independent access ports that can all be served in the same clock cycle. The storage is two banks of 4096 words of 16 bits each. The master port reaches either bank and picks one with a pair of active-low bank selects that must never both be low. The two side ports each have one active-low select and are wired to one bank only: side port A to bank 0 and side port B to bank 1. No port ever waits, and there is no arbitration between them.

Each port has a 12-bit word address, write data, an active-low read/write line (low means write) and an active-low output enable. A read returns its data one clock later, together with a valid strobe and a drive enable. When no read result is present, the port's data output is held at zero and its drive enable is low. The block also reports two conditions. One is a one-cycle error pulse when both master bank selects are low. The other is a standby indication when both master selects and the side port B select are all high.

Top module: `tpm_tri_mem`

## Requirements
- R1: Each bank holds 4096 words of 16 bits, indexed by a 12-bit address. Address 4095 of bank 0 and address 4095 of bank 1 are distinct words.
- R2: On the master port, select 0 low with select 1 high addresses bank 0, and select 1 low with select 0 high addresses bank 1. With one select low, read/write low writes and read/write high with output enable low reads.
- R3: When both master selects are low, the master port neither reads nor writes. In the following cycle the error output is high and the master valid is low. In any other cycle the error output is low in the following cycle.
- R4: Side port A always uses bank 0 and side port B always uses bank 1. On either side port, select low with read/write low writes, and select low with read/write high and output enable low reads.
- R5: A port whose select is high, or the master port with both selects high, makes no access. Its valid and drive enable are low and its data output is zero in the following cycle.
- R6: With read/write high and output enable high, no read takes place. During a write, the output enable has no effect on the write.
- R7: The standby output is high in the cycle after one where both master selects and the side port B select are all high, and low in the cycle after any other cycle.
- R8: Read data appears on the clock edge that follows the request, with valid and drive enable both high for exactly that cycle. Otherwise the data output is zero and both strobes are low. After reset all strobes, the error output and standby are low.
- R9: If the master port and a side port write the same word of the same bank in the same cycle, the master data is stored.
- R10: All three ports are served in every cycle with no stall. A read of a word that another port writes in the same cycle returns the word's previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_addr | input | 12 | Master word address within the chosen bank |
| mst_wdata | input | 16 | Master write data |
| mst_rw_n | input | 1 | Master read/write, low writes |
| mst_oe_n | input | 1 | Master output enable, active low |
| mst_bsel0_n | input | 1 | Master bank 0 select, active low |
| mst_bsel1_n | input | 1 | Master bank 1 select, active low |
| mst_rdata | output | 16 | Master read data, zero when not valid |
| mst_rvalid | output | 1 | Master read data valid |
| mst_drive_en | output | 1 | Master data output drive enable |
| sa_addr | input | 12 | Side port A address (bank 0) |
| sa_wdata | input | 16 | Side port A write data |
| sa_rw_n | input | 1 | Side port A read/write, low writes |
| sa_oe_n | input | 1 | Side port A output enable, active low |
| sa_sel_n | input | 1 | Side port A select, active low |
| sa_rdata | output | 16 | Side port A read data |
| sa_rvalid | output | 1 | Side port A read data valid |
| sa_drive_en | output | 1 | Side port A drive enable |
| sb_addr | input | 12 | Side port B address (bank 1) |
| sb_wdata | input | 16 | Side port B write data |
| sb_rw_n | input | 1 | Side port B read/write, low writes |
| sb_oe_n | input | 1 | Side port B output enable, active low |
| sb_sel_n | input | 1 | Side port B select, active low |
| sb_rdata | output | 16 | Side port B read data |
| sb_rvalid | output | 1 | Side port B read data valid |
| sb_drive_en | output | 1 | Side port B drive enable |
| dual_sel_err | output | 1 | One-cycle pulse after both master selects were low |
| standby | output | 1 | Standby indication, registered |

## Verification
Directed cycles write the top word of both banks with different values and read both back in one cycle, which separates the banks. They cross-read between the master and each side port, which exposes a bank mix-up. They hit one word with a master write and a side write together, which exposes the write priority, and read a word while it is being written, which separates read-before-write from write-through. Illegal dual selects, output-enable-high reads, deselected writes and the standby combinations are each followed by a read-back, so a stray access shows at the ports. A long seeded random run then draws addresses from a small pool that includes the top two words. This produces frequent same-word collisions across all three ports, and each output is compared every cycle with a bench model of the two banks.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

  typedef enum logic [1:0] {
    TPM_IDLE  = 2'd0,
    TPM_READ  = 2'd1,
    TPM_WRITE = 2'd2,
    TPM_BAD   = 2'd3
  } tpm_op_e;

  // Single active-low select: write wins over read, output enable gates reads only.
  function automatic tpm_op_e tpm_single_op(input logic sel_n, input logic rw_n,
                                            input logic oe_n);
    if (sel_n)  return TPM_IDLE;
    if (!rw_n)  return TPM_WRITE;
    if (!oe_n)  return TPM_READ;
    return TPM_IDLE;
  endfunction

  // Pair of mutually exclusive active-low selects: both low is illegal, no access.
  function automatic tpm_op_e tpm_dual_op(input logic sel0_n, input logic sel1_n,
                                          input logic rw_n, input logic oe_n);
    if (!sel0_n && !sel1_n) return TPM_BAD;
    return tpm_single_op(sel0_n & sel1_n, rw_n, oe_n);
  endfunction

  // Same-word collision between two write requests.
  function automatic logic tpm_same_word(input logic we_a, input logic we_b,
                                         input logic [31:0] addr_a,
                                         input logic [31:0] addr_b);
    return we_a && we_b && (addr_a == addr_b);
  endfunction

endpackage

// File: rtl/tpm_port_dec.sv
module tpm_port_dec
  import tpm_pkg::*;
#(
  parameter int unsigned NUM_EN    = 1,
  parameter bit          HOME_BANK = 1'b0
) (
  input  logic [NUM_EN-1:0] en_n,
  input  logic              rw_n,
  input  logic              oe_n,
  output logic              wr,
  output logic              rd,
  output logic              bank,
  output logic              bad
);

  tpm_op_e op;

  generate
    if (NUM_EN == 2) begin : g_dual
      always_comb begin
        op   = tpm_dual_op(en_n[0], en_n[NUM_EN-1], rw_n, oe_n);
        bank = en_n[0];
      end
    end else begin : g_single
      always_comb begin
        op   = tpm_single_op(en_n[0], rw_n, oe_n);
        bank = HOME_BANK;
      end
    end
  endgenerate

  assign wr  = (op == TPM_WRITE);
  assign rd  = (op == TPM_READ);
  assign bad = (op == TPM_BAD);

endmodule

// File: rtl/tpm_bank.sv
module tpm_bank
  import tpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              p_we,
  input  logic              p_re,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [DATA_W-1:0] p_wdata,
  output logic [DATA_W-1:0] p_rdata,
  input  logic              s_we,
  input  logic              s_re,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Secondary write is dropped when the primary hits the same word.
  logic same_word;
  logic s_commit;
  assign same_word = tpm_same_word(p_we, s_we, 32'(p_addr), 32'(s_addr));
  assign s_commit  = s_we && !same_word;

  // Reads sample the old content: non-blocking writes land after the reads.
  always_ff @(posedge clk) begin
    if (p_re)     p_rdata <= mem[p_addr];
    if (s_re)     s_rdata <= mem[s_addr];
    if (s_commit) mem[s_addr] <= s_wdata;
    if (p_we)     mem[p_addr] <= p_wdata;
  end

endmodule

// File: rtl/tpm_tri_mem.sv
module tpm_tri_mem
  import tpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mst_addr,
  input  logic [DATA_W-1:0] mst_wdata,
  input  logic              mst_rw_n,
  input  logic              mst_oe_n,
  input  logic              mst_bsel0_n,
  input  logic              mst_bsel1_n,
  output logic [DATA_W-1:0] mst_rdata,
  output logic              mst_rvalid,
  output logic              mst_drive_en,
  input  logic [ADDR_W-1:0] sa_addr,
  input  logic [DATA_W-1:0] sa_wdata,
  input  logic              sa_rw_n,
  input  logic              sa_oe_n,
  input  logic              sa_sel_n,
  output logic [DATA_W-1:0] sa_rdata,
  output logic              sa_rvalid,
  output logic              sa_drive_en,
  input  logic [ADDR_W-1:0] sb_addr,
  input  logic [DATA_W-1:0] sb_wdata,
  input  logic              sb_rw_n,
  input  logic              sb_oe_n,
  input  logic              sb_sel_n,
  output logic [DATA_W-1:0] sb_rdata,
  output logic              sb_rvalid,
  output logic              sb_drive_en,
  output logic              dual_sel_err,
  output logic              standby
);

  localparam int unsigned NBANK = 2;

  // ---------------- per-port decode ----------------
  logic m_wr, m_rd, m_bank, m_bad;
  logic a_wr, a_rd, a_bank, a_bad;
  logic b_wr, b_rd, b_bank, b_bad;

  tpm_port_dec #(.NUM_EN(2), .HOME_BANK(1'b0)) u_dec_mst (
    .en_n ({mst_bsel1_n, mst_bsel0_n}),
    .rw_n (mst_rw_n), .oe_n (mst_oe_n),
    .wr (m_wr), .rd (m_rd), .bank (m_bank), .bad (m_bad)
  );

  tpm_port_dec #(.NUM_EN(1), .HOME_BANK(1'b0)) u_dec_sa (
    .en_n (sa_sel_n),
    .rw_n (sa_rw_n), .oe_n (sa_oe_n),
    .wr (a_wr), .rd (a_rd), .bank (a_bank), .bad (a_bad)
  );

  tpm_port_dec #(.NUM_EN(1), .HOME_BANK(1'b1)) u_dec_sb (
    .en_n (sb_sel_n),
    .rw_n (sb_rw_n), .oe_n (sb_oe_n),
    .wr (b_wr), .rd (b_rd), .bank (b_bank), .bad (b_bad)
  );

  // Named events for checking.
  logic sel_conflict;
  logic sleep_now;
  assign sel_conflict = m_bad | a_bad | b_bad;
  assign sleep_now    = mst_bsel0_n & mst_bsel1_n & sb_sel_n;

  // ---------------- bank request routing ----------------
  logic [NBANK-1:0]  bk_pwe, bk_pre, bk_swe, bk_sre;
  logic [ADDR_W-1:0] bk_saddr  [NBANK];
  logic [DATA_W-1:0] bk_swdata [NBANK];
  logic [DATA_W-1:0] bk_prdata [NBANK];
  logic [DATA_W-1:0] bk_srdata [NBANK];

  always_comb begin
    for (int i = 0; i < NBANK; i++) begin
      bk_pwe[i]    = m_wr && (m_bank == i[0]);
      bk_pre[i]    = m_rd && (m_bank == i[0]);
      bk_swe[i]    = (a_wr && (a_bank == i[0])) || (b_wr && (b_bank == i[0]));
      bk_sre[i]    = (a_rd && (a_bank == i[0])) || (b_rd && (b_bank == i[0]));
      bk_saddr[i]  = (a_bank == i[0]) ? sa_addr  : sb_addr;
      bk_swdata[i] = (a_bank == i[0]) ? sa_wdata : sb_wdata;
    end
  end

  generate
    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
      tpm_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .p_we    (bk_pwe[gb]),
        .p_re    (bk_pre[gb]),
        .p_addr  (mst_addr),
        .p_wdata (mst_wdata),
        .p_rdata (bk_prdata[gb]),
        .s_we    (bk_swe[gb]),
        .s_re    (bk_sre[gb]),
        .s_addr  (bk_saddr[gb]),
        .s_wdata (bk_swdata[gb]),
        .s_rdata (bk_srdata[gb])
      );
    end
  endgenerate

  // ---------------- response registers ----------------
  logic m_vld_q, m_bank_q, a_vld_q, b_vld_q, err_q, sleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld_q  <= 1'b0;
      m_bank_q <= 1'b0;
      a_vld_q  <= 1'b0;
      b_vld_q  <= 1'b0;
      err_q    <= 1'b0;
      sleep_q  <= 1'b0;
    end else begin
      m_vld_q  <= m_rd;
      m_bank_q <= m_bank;
      a_vld_q  <= a_rd;
      b_vld_q  <= b_rd;
      err_q    <= sel_conflict;
      sleep_q  <= sleep_now;
    end
  end

  assign mst_rdata    = m_vld_q ? bk_prdata[m_bank_q] : '0;
  assign mst_rvalid   = m_vld_q;
  assign mst_drive_en = m_vld_q;
  assign sa_rdata     = a_vld_q ? bk_srdata[a_bank] : '0;
  assign sa_rvalid    = a_vld_q;
  assign sa_drive_en  = a_vld_q;
  assign sb_rdata     = b_vld_q ? bk_srdata[b_bank] : '0;
  assign sb_rvalid    = b_vld_q;
  assign sb_drive_en  = b_vld_q;
  assign dual_sel_err = err_q;
  assign standby      = sleep_q;

  // ---------------- assertions ----------------
  assert_dual_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_bsel0_n && !mst_bsel1_n) |=> (dual_sel_err && !mst_rvalid));

  assert_err_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_bsel0_n || mst_bsel1_n) |=> !dual_sel_err);

  assert_desel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sa_sel_n |=> (!sa_drive_en && (sa_rdata == '0)));

  assert_oe_blocks_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_oe_n && sb_rw_n) |=> !sb_rvalid);

  assert_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_bsel0_n && mst_bsel1_n && sb_sel_n) |=> standby);

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sa_sel_n && sa_rw_n && !sa_oe_n) |=> (sa_rvalid && sa_drive_en));

endmodule

// File: tb/tpm_tri_mem_bench.sv
module tpm_tri_mem_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [11:0] mst_addr, sa_addr, sb_addr;
  logic [15:0] mst_wdata, sa_wdata, sb_wdata;
  logic mst_rw_n, mst_oe_n, mst_bsel0_n, mst_bsel1_n;
  logic sa_rw_n, sa_oe_n, sa_sel_n, sb_rw_n, sb_oe_n, sb_sel_n;
  logic [15:0] mst_rdata, sa_rdata, sb_rdata;
  logic mst_rvalid, mst_drive_en, sa_rvalid, sa_drive_en, sb_rvalid, sb_drive_en;
  logic dual_sel_err, standby;

  tpm_tri_mem u_tpm_tri_mem (.*);

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R8";

  logic [15:0] ref0 [4096];
  logic [15:0] ref1 [4096];

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, got, exp);
    end
  endtask

  // 0 idle, 1 read, 2 write
  function automatic int kind(input logic sel_n, input logic rw_n, input logic oe_n);
    if (sel_n === 1'b1) return 0;
    return (rw_n === 1'b0) ? 2 : ((oe_n === 1'b0) ? 1 : 0);
  endfunction

  task automatic idle_all();
    mst_bsel0_n = 1; mst_bsel1_n = 1; mst_rw_n = 1; mst_oe_n = 1;
    sa_sel_n = 1; sa_rw_n = 1; sa_oe_n = 1;
    sb_sel_n = 1; sb_rw_n = 1; sb_oe_n = 1;
    mst_addr = 0; sa_addr = 0; sb_addr = 0;
    mst_wdata = 0; sa_wdata = 0; sb_wdata = 0;
  endtask

  task automatic run_cycle();
    logic m_ill, m_one, m_bk;
    int mk, ak, bk;
    logic [15:0] em, ea, eb;
    logic exp_sleep;
    m_ill = !mst_bsel0_n && !mst_bsel1_n;
    m_one = mst_bsel0_n ^ mst_bsel1_n;
    m_bk  = mst_bsel0_n;
    mk = m_one ? kind(1'b0, mst_rw_n, mst_oe_n) : 0;
    ak = kind(sa_sel_n, sa_rw_n, sa_oe_n);
    bk = kind(sb_sel_n, sb_rw_n, sb_oe_n);
    em = (mk == 1) ? (m_bk ? ref1[mst_addr] : ref0[mst_addr]) : 16'h0;
    ea = (ak == 1) ? ref0[sa_addr] : 16'h0;
    eb = (bk == 1) ? ref1[sb_addr] : 16'h0;
    exp_sleep = mst_bsel0_n && mst_bsel1_n && sb_sel_n;
    if (ak == 2) ref0[sa_addr] = sa_wdata;
    if (bk == 2) ref1[sb_addr] = sb_wdata;
    if (mk == 2) begin
      if (m_bk) ref1[mst_addr] = mst_wdata; else ref0[mst_addr] = mst_wdata;
    end
    @(posedge clk);
    #1;
    chk("mst_rvalid", 32'(mst_rvalid), 32'(mk == 1));
    chk("mst_drive_en", 32'(mst_drive_en), 32'(mk == 1));
    chk("mst_rdata", 32'(mst_rdata), 32'(em));
    chk("sa_rvalid", 32'(sa_rvalid), 32'(ak == 1));
    chk("sa_drive_en", 32'(sa_drive_en), 32'(ak == 1));
    chk("sa_rdata", 32'(sa_rdata), 32'(ea));
    chk("sb_rvalid", 32'(sb_rvalid), 32'(bk == 1));
    chk("sb_drive_en", 32'(sb_drive_en), 32'(bk == 1));
    chk("sb_rdata", 32'(sb_rdata), 32'(eb));
    chk("dual_sel_err", 32'(dual_sel_err), 32'(m_ill));
    chk("standby", 32'(standby), 32'(exp_sleep));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h0003_C0DE));
    idle_all();
    repeat (3) @(posedge clk);
    #1;
    cur_tag = "R8";
    chk("reset mst_rvalid", 32'(mst_rvalid), 0);
    chk("reset sa_drive_en", 32'(sa_drive_en), 0);
    chk("reset dual_sel_err", 32'(dual_sel_err), 0);
    chk("reset standby", 32'(standby), 0);
    rst_n = 1'b1;
    run_cycle();

    // R1: top word of both banks is distinct
    cur_tag = "R1";
    idle_all(); mst_bsel0_n = 0; mst_rw_n = 0; mst_addr = 12'hFFF; mst_wdata = 16'h1234; run_cycle();
    idle_all(); mst_bsel1_n = 0; mst_rw_n = 0; mst_addr = 12'hFFF; mst_wdata = 16'hABCD; run_cycle();
    idle_all(); sa_sel_n = 0; sa_oe_n = 0; sa_addr = 12'hFFF;
    sb_sel_n = 0; sb_oe_n = 0; sb_addr = 12'hFFF; run_cycle();

    // R2: master reads each bank by select
    cur_tag = "R2";
    idle_all(); mst_bsel1_n = 0; mst_oe_n = 0; mst_addr = 12'hFFF; run_cycle();
    idle_all(); mst_bsel0_n = 0; mst_oe_n = 0; mst_addr = 12'hFFF; run_cycle();

    // R4: side ports land in their own banks
    cur_tag = "R4";
    idle_all(); sa_sel_n = 0; sa_rw_n = 0; sa_addr = 5; sa_wdata = 16'h5555;
    sb_sel_n = 0; sb_rw_n = 0; sb_addr = 5; sb_wdata = 16'h3333; run_cycle();
    idle_all(); mst_bsel0_n = 0; mst_oe_n = 0; mst_addr = 5; run_cycle();
    idle_all(); mst_bsel1_n = 0; mst_oe_n = 0; mst_addr = 5; run_cycle();

    // R3: both selects low makes no access
    cur_tag = "R3";
    idle_all(); mst_bsel0_n = 0; mst_bsel1_n = 0; mst_rw_n = 0; mst_addr = 5; mst_wdata = 16'hFFFF; run_cycle();
    idle_all(); mst_bsel0_n = 0; mst_bsel1_n = 0; mst_oe_n = 0; mst_addr = 5; run_cycle();
    idle_all(); sa_sel_n = 0; sa_oe_n = 0; sa_addr = 5; sb_sel_n = 0; sb_oe_n = 0; sb_addr = 5; run_cycle();

    // R6: output enable high blocks reads, ignored on writes
    cur_tag = "R6";
    idle_all(); mst_bsel0_n = 0; mst_addr = 5; run_cycle();
    idle_all(); sa_sel_n = 0; sa_rw_n = 0; sa_oe_n = 1; sa_addr = 9; sa_wdata = 16'h0909; run_cycle();
    idle_all(); sa_sel_n = 0; sa_oe_n = 0; sa_addr = 9; run_cycle();

    // R5: deselected write is ignored
    cur_tag = "R5";
    idle_all(); sb_sel_n = 1; sb_rw_n = 0; sb_addr = 5; sb_wdata = 16'hDEAD; run_cycle();
    idle_all(); sb_sel_n = 0; sb_oe_n = 0; sb_addr = 5; run_cycle();

    // R9: master wins a same-word collision
    cur_tag = "R9";
    idle_all(); mst_bsel0_n = 0; mst_rw_n = 0; mst_addr = 7; mst_wdata = 16'hAAAA;
    sa_sel_n = 0; sa_rw_n = 0; sa_addr = 7; sa_wdata = 16'h5A5A; run_cycle();
    idle_all(); sa_sel_n = 0; sa_oe_n = 0; sa_addr = 7; run_cycle();

    // R10: read during write returns the old word
    cur_tag = "R10";
    idle_all(); mst_bsel0_n = 0; mst_rw_n = 0; mst_addr = 7; mst_wdata = 16'h1111;
    sa_sel_n = 0; sa_oe_n = 0; sa_addr = 7; run_cycle();
    idle_all(); sa_sel_n = 0; sa_oe_n = 0; sa_addr = 7; run_cycle();

    // R7: standby combinations
    cur_tag = "R7";
    idle_all(); run_cycle();
    idle_all(); sa_sel_n = 0; run_cycle();
    idle_all(); sb_sel_n = 0; run_cycle();
    idle_all(); mst_bsel1_n = 0; run_cycle();

    // Random mix: all ports every cycle, small address pool
    cur_tag = "R10";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 8);
      mst_bsel0_n = !(r < 3 || r == 7);
      mst_bsel1_n = !((r >= 3 && r < 6) || r == 7);
      mst_rw_n = 1'($urandom); mst_oe_n = ($urandom % 4) == 0;
      sa_sel_n = ($urandom % 4) == 0; sa_rw_n = 1'($urandom); sa_oe_n = ($urandom % 4) == 0;
      sb_sel_n = ($urandom % 4) == 0; sb_rw_n = 1'($urandom); sb_oe_n = ($urandom % 4) == 0;
      mst_addr = (($urandom % 4) == 0) ? 12'hFFF - 12'($urandom % 2) : 12'($urandom % 8);
      sa_addr  = (($urandom % 4) == 0) ? 12'hFFF - 12'($urandom % 2) : 12'($urandom % 8);
      sb_addr  = (($urandom % 4) == 0) ? 12'hFFF - 12'($urandom % 2) : 12'($urandom % 8);
      mst_wdata = 16'($urandom); sa_wdata = 16'($urandom); sb_wdata = 16'($urandom);
      run_cycle();
    end

    finish_run();
  end

endmodule